// File: doc/BRIEF.md
# Packet Page Allocation Unit

This block manages a small pool of fixed-size packet pages for an Ethernet controller. It keeps a bitmask of the pages in use, hands out the lowest-numbered free page, and holds two short queues of page numbers. One queue lists pages waiting to be sent. The other lists received pages waiting for the host. The block also keeps an interrupt status byte and an interrupt mask byte, and drives one interrupt line.

The host controls the block with a command byte, a packet-number register, an acknowledge write and a mask write. It reads back the allocation result, both queue heads, the count of used pages, the pool size, the status and the mask.

Two side ports use valid/ready handshakes:
- A receive engine raises `rx_alloc_valid` to claim a page. A transfer happens in the cycle where `rx_alloc_valid` and `rx_alloc_ready` are both high. `rx_alloc_page` names the granted page in that cycle, and the page is pushed onto the receive queue. `rx_alloc_ready` is low when no page is free, in any cycle with a host command, and in any cycle with a drain handshake. The engine must hold valid until ready.
- A transmit engine drains the transmit queue through `tx_drain_valid`/`tx_drain_ready`, one page per handshake. `tx_drain_valid` drops in any cycle that carries a host command, because host commands take priority.

A host command and a handshake never act in the same cycle. The packet-number register is written with `pnum_wr`. The new value is used by commands from the next cycle on.

Top module: `pbau_top`

## Requirements
- R1: After reset the block reads as follows: status 0x04, mask 0x00, allocation result 0x00, both queue heads 0x80, used-page count 0, and pool size 4 (parameter PAGES).
- R2: The command code sits in bits 7:5 of `cmd_byte`. Code 1 (allocate for transmit) clears ALLOC (status bit 3) and grants the lowest free page: the result takes the page number and ALLOC is set. If no page is free, the result is 0x80 and ALLOC stays clear.
- R3: While the result reads 0x80, any page release retries the allocation in the same cycle. On success the result takes the granted page and ALLOC is set.
- R4: Code 5 releases the page named by the packet-number register, which lowers the used-page count. Numbers of PAGES or more are ignored.
- R5: Code 6 appends the packet-number page to the transmit queue, and `tx_head` shows the oldest entry. A push onto a full queue (PAGES entries) is ignored. Code 7 empties the transmit queue.
- R6: Status bit 2 (TX_EMPTY) is set in every cycle that the transmit queue is empty, even right after an acknowledge.
- R7: An acknowledge write clears only the status bits given by `ack_data & 0xD6`. ALLOC (bit 3) and RCV (bit 0) are never cleared this way.
- R8: `irq` is high exactly when status AND mask is nonzero. `mask_wr` loads the mask.
- R9: A receive handshake allocates the lowest free page, pushes it onto the receive queue and sets RCV (bit 0). `rx_alloc_ready` is low when the pool is full, when `cmd_wr` is high, or when a drain handshake occurs.
- R10: Code 3 pops the receive queue. RCV stays set while entries remain and clears once the queue is empty. Code 4 first releases the head page, then pops. An empty queue head reads 0x80.
- R11: `tx_drain_valid` is high when the transmit queue is not empty and no host command is present. `tx_drain_page` shows the head. A handshake pops the head. With `auto_release` high the popped page is freed; with it low, TX (bit 1) is set.
- R12: Code 2 clears the page bitmask, both queues and any pending allocation, so the result reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_release | input | 1 | Free each drained transmit page instead of flagging TX |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte, code in bits 7:5 |
| pnum_wr | input | 1 | Packet-number register write strobe |
| pnum_data | input | 8 | Packet-number write value |
| ack_wr | input | 1 | Interrupt acknowledge strobe |
| ack_data | input | 8 | Bits to acknowledge (masked with 0xD6) |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | New interrupt mask |
| rx_alloc_valid | input | 1 | Receive engine requests a page |
| rx_alloc_ready | output | 1 | A page can be granted this cycle |
| rx_alloc_page | output | 8 | Page granted on the receive handshake |
| tx_drain_valid | output | 1 | Transmit queue head is offered |
| tx_drain_ready | input | 1 | Transmit engine takes the head |
| tx_drain_page | output | 8 | Transmit queue head page |
| alloc_result | output | 8 | Last transmit allocation result, 0x80 when pending |
| tx_head | output | 8 | Transmit queue head, 0x80 when empty |
| rx_head | output | 8 | Receive queue head, 0x80 when empty |
| used_pages | output | 8 | Number of allocated pages |
| mem_pages | output | 8 | Pool size in pages |
| irq_status | output | 8 | Interrupt status byte |
| irq_mask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench starts with directed runs of the allocator:
- Filling the pool one page at a time checks that grants go lowest page first.
- A request on a full pool, followed by a release, separates a dropped allocation from a pending one that completes on release.
- Transmit pushes beyond capacity, drains with and without auto-release, and acknowledge values that include protected bits separate the TX, TX_EMPTY and ALLOC paths.

Receive requests are then issued back to back, then against a host command, then against a full pool, so that each cause of a low ready is seen on its own. A closing run of pseudo-random commands and handshakes mixes every code with concurrent acknowledges and releases.

// File: rtl/pbau_pkg.sv
`timescale 1ns/1ps
package pbau_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_TXALLOC   = 3'd1,
    OP_UNIT_RST  = 3'd2,
    OP_RX_POP    = 3'd3,
    OP_RX_FREE   = 3'd4,
    OP_PAGE_FREE = 3'd5,
    OP_TX_PUSH   = 3'd6,
    OP_TX_CLR    = 3'd7
  } mmu_op_e;

  localparam logic [7:0] IRQ_RCV   = 8'h01;
  localparam logic [7:0] IRQ_TX    = 8'h02;
  localparam logic [7:0] IRQ_TXE   = 8'h04;
  localparam logic [7:0] IRQ_ALLOC = 8'h08;
  localparam logic [7:0] ACK_MASK  = 8'hD6;
  localparam logic [7:0] NO_PAGE   = 8'h80;
endpackage

// File: rtl/pbau_pool.sv
`timescale 1ns/1ps
module pbau_pool #(
  parameter int PAGES = 4,
  parameter int IDXW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            rel_en,
  input  logic [IDXW-1:0] rel_idx,
  input  logic            alloc_req,
  output logic            grant_ok,
  output logic [IDXW-1:0] grant_idx,
  output logic            has_free,
  output logic [7:0]      used_cnt
);
  logic [PAGES-1:0] used_q, rel_vec, grant_vec, after_rel, used_n;
  logic             found;

  // one-hot decode of the release and grant page numbers
  for (genvar g = 0; g < PAGES; g++) begin : g_dec
    assign rel_vec[g]   = rel_en   && (rel_idx   == IDXW'(g));
    assign grant_vec[g] = grant_ok && (grant_idx == IDXW'(g));
  end

  assign after_rel = used_q & ~rel_vec;

  // lowest free page, searched after this cycle's release
  always_comb begin
    found     = 1'b0;
    grant_idx = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (!after_rel[i]) begin
        found     = 1'b1;
        grant_idx = IDXW'(i);
      end
    end
  end

  assign grant_ok = alloc_req && found;
  assign has_free = ~&used_q;
  assign used_n   = clear ? '0 : (after_rel | grant_vec);

  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < PAGES; i++) used_cnt = used_cnt + 8'(used_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_n;
  end

  assert_grant_marks_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ok && !clear |=> used_q[$past(grant_idx)]);

  assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && !alloc_req && !clear |=> !used_q[$past(rel_idx)]);
endmodule

// File: rtl/pbau_queue.sv
`timescale 1ns/1ps
module pbau_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          empty_next
);
  logic [DEPTH-1:0][W-1:0] mem, shifted, nxt;
  logic [CW-1:0]           cnt_n;
  logic                    full;

  // entries moved one place toward the head on a pop
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g == DEPTH - 1) begin : g_last
      assign shifted[g] = '0;
    end else begin : g_mid
      assign shifted[g] = mem[g+1];
    end
  end

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[0];

  always_comb begin
    nxt   = mem;
    cnt_n = count;
    if (pop && !empty) begin
      nxt   = shifted;
      cnt_n = count - CW'(1);
    end
    if (push && cnt_n != CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == cnt_n) nxt[i] = push_data;
      cnt_n = cnt_n + CW'(1);
    end
    if (clear) cnt_n = '0;
  end

  assign empty_next = (cnt_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem   <= '0;
      count <= '0;
    end else begin
      mem   <= nxt;
      count <= cnt_n;
    end
  end

  assert_full_push_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clear |=> count == CW'(DEPTH) && head == $past(head));

  assert_last_pop_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'(1) && pop && !push |=> empty);
endmodule

// File: rtl/pbau_top.sv
`timescale 1ns/1ps
module pbau_top #(
  parameter int PAGES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_release,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       pnum_wr,
  input  logic [7:0] pnum_data,
  input  logic       ack_wr,
  input  logic [7:0] ack_data,
  input  logic       mask_wr,
  input  logic [7:0] mask_data,
  input  logic       rx_alloc_valid,
  output logic       rx_alloc_ready,
  output logic [7:0] rx_alloc_page,
  output logic       tx_drain_valid,
  input  logic       tx_drain_ready,
  output logic [7:0] tx_drain_page,
  output logic [7:0] alloc_result,
  output logic [7:0] tx_head,
  output logic [7:0] rx_head,
  output logic [7:0] used_pages,
  output logic [7:0] mem_pages,
  output logic [7:0] irq_status,
  output logic [7:0] irq_mask,
  output logic       irq
);
  import pbau_pkg::*;

  localparam int IDXW = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int CW   = $clog2(PAGES + 1);

  mmu_op_e         op;
  logic            is_alloc, is_urst, is_rxpop, is_rxfree, is_pfree, is_push, is_txclr;
  logic [7:0]      pnum_q;
  logic            pnum_ok;
  logic [IDXW-1:0] pnum_idx;
  logic            drain_hs, rx_hs, pending, retry, tx_grant;
  logic            rel_en, alloc_req, grant_ok, has_free;
  logic [IDXW-1:0] rel_idx, grant_idx;
  logic [IDXW-1:0] txq_head, rxq_head;
  logic [CW-1:0]   txq_cnt, rxq_cnt;
  logic            txq_empty, rxq_empty, txq_empty_n, rxq_empty_n;
  logic [7:0]      st_n;
  logic            unused_low;

  assign unused_low = ^cmd_byte[4:0];

  // command decode; a command only acts with its strobe
  assign op        = mmu_op_e'(cmd_byte[7:5]);
  assign is_alloc  = cmd_wr && op == OP_TXALLOC;
  assign is_urst   = cmd_wr && op == OP_UNIT_RST;
  assign is_rxpop  = cmd_wr && op == OP_RX_POP;
  assign is_rxfree = cmd_wr && op == OP_RX_FREE;
  assign is_pfree  = cmd_wr && op == OP_PAGE_FREE;
  assign is_push   = cmd_wr && op == OP_TX_PUSH;
  assign is_txclr  = cmd_wr && op == OP_TX_CLR;

  assign pnum_ok  = pnum_q < 8'(PAGES);
  assign pnum_idx = pnum_q[IDXW-1:0];

  // side ports: host first, then drain, then receive allocation
  assign tx_drain_valid = !txq_empty && !cmd_wr;
  assign tx_drain_page  = 8'(txq_head);
  assign drain_hs       = tx_drain_valid && tx_drain_ready;
  assign rx_alloc_ready = !cmd_wr && !drain_hs && has_free;
  assign rx_hs          = rx_alloc_valid && rx_alloc_ready;
  assign rx_alloc_page  = 8'(grant_idx);

  always_comb begin
    rel_en  = 1'b0;
    rel_idx = '0;
    if (is_rxfree && !rxq_empty) begin
      rel_en  = 1'b1;
      rel_idx = rxq_head;
    end else if (is_pfree && pnum_ok) begin
      rel_en  = 1'b1;
      rel_idx = pnum_idx;
    end else if (drain_hs && auto_release) begin
      rel_en  = 1'b1;
      rel_idx = txq_head;
    end
  end

  assign pending   = (alloc_result == NO_PAGE);
  assign retry     = rel_en && pending;
  assign alloc_req = is_alloc || retry || rx_hs;
  assign tx_grant  = grant_ok && !rx_hs;

  pbau_pool #(.PAGES(PAGES), .IDXW(IDXW)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (is_urst),
    .rel_en    (rel_en),
    .rel_idx   (rel_idx),
    .alloc_req (alloc_req),
    .grant_ok  (grant_ok),
    .grant_idx (grant_idx),
    .has_free  (has_free),
    .used_cnt  (used_pages)
  );

  pbau_queue #(.DEPTH(PAGES), .W(IDXW)) u_txq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (is_txclr || is_urst),
    .push       (is_push && pnum_ok),
    .push_data  (pnum_idx),
    .pop        (drain_hs),
    .head       (txq_head),
    .count      (txq_cnt),
    .empty      (txq_empty),
    .empty_next (txq_empty_n)
  );

  pbau_queue #(.DEPTH(PAGES), .W(IDXW)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (is_urst),
    .push       (rx_hs),
    .push_data  (grant_idx),
    .pop        (is_rxpop || is_rxfree),
    .head       (rxq_head),
    .count      (rxq_cnt),
    .empty      (rxq_empty),
    .empty_next (rxq_empty_n)
  );

  assign tx_head   = txq_empty ? NO_PAGE : 8'(txq_head);
  assign rx_head   = rxq_empty ? NO_PAGE : 8'(rxq_head);
  assign mem_pages = 8'(PAGES);

  // next interrupt status: acknowledge, then events, then the empty force
  always_comb begin
    st_n = irq_status & ~(ack_wr ? (ack_data & ACK_MASK) : 8'h00);
    if (is_alloc) st_n = st_n & ~IRQ_ALLOC;
    if (tx_grant) st_n = st_n | IRQ_ALLOC;
    if (rx_hs) st_n = st_n | IRQ_RCV;
    if (is_rxpop || is_rxfree)
      st_n = rxq_empty_n ? (st_n & ~IRQ_RCV) : (st_n | IRQ_RCV);
    if (drain_hs && !auto_release) st_n = st_n | IRQ_TX;
    if (txq_empty_n) st_n = st_n | IRQ_TXE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_status   <= IRQ_TXE;
      irq_mask     <= 8'h00;
      alloc_result <= 8'h00;
      pnum_q       <= 8'h00;
    end else begin
      irq_status <= st_n;
      if (mask_wr) irq_mask <= mask_data;
      if (pnum_wr) pnum_q <= pnum_data;
      if (is_urst)                alloc_result <= 8'h00;
      else if (is_alloc)          alloc_result <= grant_ok ? 8'(grant_idx) : NO_PAGE;
      else if (retry && grant_ok) alloc_result <= 8'(grant_idx);
    end
  end

  assign irq = |(irq_status & irq_mask);

  assert_txe_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    txq_cnt == '0 |-> irq_status[2]);

  assert_alloc_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_alloc && !has_free |=> alloc_result == NO_PAGE && !irq_status[3]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask == 8'h00 |-> !irq);

  assert_rx_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hs |=> rxq_cnt == $past(rxq_cnt) + CW'(1) && irq_status[0]);

  assert_drain_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drain_hs |=> txq_cnt == $past(txq_cnt) - CW'(1));

  assert_unit_rst_R12: assert property (@(posedge clk) disable iff (!rst_n)
    is_urst |=> used_pages == 8'h00 && alloc_result == 8'h00 && rx_head == NO_PAGE);
endmodule

// File: tb/sim_pbau_top.sv
`timescale 1ns/1ps
module sim_pbau_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_release = 1'b0;
  logic cmd_wr = 1'b0, pnum_wr = 1'b0, ack_wr = 1'b0, mask_wr = 1'b0;
  logic [7:0] cmd_byte = '0, pnum_data = '0, ack_data = '0, mask_data = '0;
  logic rx_alloc_valid = 1'b0, tx_drain_ready = 1'b0;
  logic rx_alloc_ready, tx_drain_valid, irq;
  logic [7:0] rx_alloc_page, tx_drain_page, alloc_result, tx_head, rx_head;
  logic [7:0] used_pages, mem_pages, irq_status, irq_mask;

  always #2.5 clk = ~clk;

  pbau_top u0 (.*);

  typedef struct {
    logic [7:0] res, txh, rxh, used, st, msk;
    logic       irq;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int bad = 0;
  bit done = 0;

  // bench-side state, built from the requirements
  int used_m, res_m, st_m, msk_m, pnum_m;
  int txq[$];
  int rxq[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int lowfree();
    for (int i = 0; i < 4; i++) if (used_m[i] == 0) return i;
    return -1;
  endfunction

  task automatic m_release(input int p);
    int g;
    used_m &= ~(1 << p);
    if (res_m == 'h80) begin
      g = lowfree();
      if (g >= 0) begin used_m |= (1 << g); res_m = g; st_m |= 'h08; end
    end
  endtask

  task automatic m_rxpop();
    if (rxq.size() > 1) begin void'(rxq.pop_front()); st_m |= 1; end
    else begin
      if (rxq.size() == 1) void'(rxq.pop_front());
      st_m &= ~1;
    end
  endtask

  // monitor: compares registered outputs one step after each driven edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(alloc_result == e.res, e.req, "alloc_result", alloc_result, e.res);
      chk(tx_head == e.txh, e.req, "tx_head", tx_head, e.txh);
      chk(rx_head == e.rxh, e.req, "rx_head", rx_head, e.rxh);
      chk(used_pages == e.used, e.req, "used_pages", used_pages, e.used);
      chk(irq_status == e.st, e.req, "irq_status", irq_status, e.st);
      chk(irq_mask == e.msk, e.req, "irq_mask", irq_mask, e.msk);
      chk(irq == e.irq, e.req, "irq", irq, e.irq);
    end
  end

  // driver: one cycle of stimulus, handshake checks and a pushed expectation
  task automatic cyc(input bit cw, input logic [7:0] cb, input bit aw, input logic [7:0] ad,
                     input bit mw, input logic [7:0] md, input bit pw, input logic [7:0] pd,
                     input bit rxv, input bit txr, input string req);
    bit drain, rdy, rxhs;
    int g, p;
    exp_t e;
    @(negedge clk);
    cmd_wr = cw; cmd_byte = cb; ack_wr = aw; ack_data = ad; mask_wr = mw; mask_data = md;
    pnum_wr = pw; pnum_data = pd; rx_alloc_valid = rxv; tx_drain_ready = txr;
    drain = !cw && txq.size() > 0 && txr;
    rdy   = !cw && !drain && used_m != 15;
    rxhs  = rxv && rdy;
    #1;
    chk(rx_alloc_ready == rdy, req, "rx_alloc_ready", rx_alloc_ready, rdy);
    chk(tx_drain_valid == (!cw && txq.size() > 0), req, "tx_drain_valid", tx_drain_valid, !cw && txq.size() > 0);
    if (!cw && txq.size() > 0) chk(tx_drain_page == txq[0], req, "tx_drain_page", tx_drain_page, txq[0]);
    if (rxhs) chk(rx_alloc_page == lowfree(), req, "rx_alloc_page", rx_alloc_page, lowfree());
    if (aw) st_m &= ~(ad & 'hD6);
    if (cw) begin
      case (cb[7:5])
        3'd1: begin
          res_m = 'h80; st_m &= ~'h08;
          g = lowfree();
          if (g >= 0) begin used_m |= (1 << g); res_m = g; st_m |= 'h08; end
        end
        3'd2: begin used_m = 0; txq.delete(); rxq.delete(); res_m = 0; end
        3'd3: m_rxpop();
        3'd4: begin if (rxq.size() > 0) m_release(rxq[0]); m_rxpop(); end
        3'd5: if (pnum_m < 4) m_release(pnum_m);
        3'd6: if (pnum_m < 4 && txq.size() < 4) txq.push_back(pnum_m);
        3'd7: txq.delete();
        default: ;
      endcase
    end else if (drain) begin
      p = txq.pop_front();
      if (auto_release) m_release(p); else st_m |= 'h02;
    end else if (rxhs) begin
      g = lowfree(); used_m |= (1 << g); rxq.push_back(g); st_m |= 1;
    end
    if (txq.size() == 0) st_m |= 'h04;
    if (mw) msk_m = md;
    if (pw) pnum_m = pd;
    e.res = 8'(res_m); e.txh = txq.size() ? 8'(txq[0]) : 8'h80;
    e.rxh = rxq.size() ? 8'(rxq[0]) : 8'h80; e.used = 8'($countones(4'(used_m)));
    e.st = 8'(st_m); e.msk = 8'(msk_m); e.irq = (st_m & msk_m) != 0; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic cmd(input logic [2:0] code, input string req);
    cyc(1, {code, 5'd0}, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic pnum(input int v, input string req);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'(v), 0, 0, req);
  endtask
  task automatic ack(input logic [7:0] v, input string req);
    cyc(0, 0, 1, v, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic setmask(input logic [7:0] v, input string req);
    cyc(0, 0, 0, 0, 1, v, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    used_m = 0; res_m = 0; st_m = 'h04; msk_m = 0; pnum_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_status == 8'h04, "R1", "status", irq_status, 8'h04);
    chk(irq_mask == 8'h00, "R1", "mask", irq_mask, 0);
    chk(alloc_result == 8'h00, "R1", "result", alloc_result, 0);
    chk(tx_head == 8'h80 && rx_head == 8'h80, "R1", "heads", {tx_head, rx_head}, 16'h8080);
    chk(used_pages == 0, "R1", "used", used_pages, 0);
    chk(mem_pages == 8'd4, "R1", "mem_pages", mem_pages, 4);
    chk(irq == 1'b0, "R1", "irq", irq, 0);

    // R2: fill pool lowest first, then a failing request
    for (int i = 0; i < 4; i++) cmd(3'd1, "R2");
    cmd(3'd1, "R2");
    // R4 and R3: release page 2 with a request pending
    pnum(2, "R4");
    cmd(3'd5, "R3");
    pnum(7, "R4");
    cmd(3'd5, "R4");
    // R5 and R7: push two pages, acknowledge everything
    pnum(0, "R5"); cmd(3'd6, "R5");
    pnum(1, "R5"); cmd(3'd6, "R5");
    ack(8'hFF, "R7");
    // R8 and R11: drain without auto-release sets TX
    setmask(8'h02, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
    ack(8'h02, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
    // R6: acknowledge of TX_EMPTY with the queue empty
    ack(8'h04, "R6");
    // R5: five pushes, the fifth ignored, then clear
    for (int i = 0; i < 5; i++) cmd(3'd6, "R5");
    cyc(1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
    cmd(3'd7, "R5");
    setmask(8'h00, "R8");
    // R12: unit reset
    cmd(3'd2, "R12");
    // R9: receive grants until full, then one against a host command
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
    cmd(3'd3, "R10");
    cyc(1, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
    // R10: release-and-pop, then pops down to empty and beyond
    cmd(3'd4, "R10");
    cmd(3'd3, "R10");
    cmd(3'd3, "R10");
    cmd(3'd3, "R10");
    cmd(3'd3, "R10");
    // R3 and R11: auto-release satisfies a pending request
    auto_release = 1'b1;
    cmd(3'd2, "R12");
    for (int i = 0; i < 5; i++) cmd(3'd1, "R2");
    pnum(3, "R11"); cmd(3'd6, "R11");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
    setmask(8'h09, "R8");
    // mixed pseudo-random run
    lf = 16'hACE1;
    for (int i = 0; i < 120; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] & lf[1], {lf[4:2], 5'd0}, lf[5], {lf[13:6]}, lf[14] & lf[7], lf[15:8],
          lf[9] & lf[3], 8'(lf[11:9] % 6), lf[12], lf[15], "R9");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule